// File: doc/BRIEF.md
# Binary FSK Tone Generator

This block turns a serial bit stream into sampled binary frequency-shift-keyed sine samples for an external DAC. A phase accumulator advances by one tuning word on every sample clock. A logic 1 (mark) uses the carrier word plus the deviation word. A logic 0 (space) uses the carrier word minus the deviation word. The accumulator is never cleared when the tone changes, so the waveform stays phase-continuous at every bit edge. The upper phase bits address a sine table that stores only one quarter of the wave.

A second accumulator, driven by its own rate word, paces the bits. Each time it wraps, one bit period ends, and the block asks the data source for the next bit. Because this accumulator keeps its fractional remainder, a bit rate that is not an integer fraction of the sample rate does not drift over time. The carrier, deviation and rate words are written at run time through a small register port. Register writes and data bits are held back and applied together at the next bit boundary, so no symbol is ever cut in two.

With the default build, the sample clock is 60 MHz and all words are 32 bits wide. This places the carrier anywhere from 5 MHz to 21 MHz in steps of 60e6/2^32 Hz. The default deviation word is about 75 kHz and the default rate word is about 39.4 kbit/s.

Top module: `fsk_nco_mod`

## Requirements
- R1: While rst_n is low, sample_out is 0 and bit_req is 0. Out of reset, the shadow and active words take the DEF_CAR, DEF_DEV and DEF_RATE parameters, the held data bit is 0, and the phase and bit accumulators are 0.
- R2: On every clock the phase advances by the active tuning word, modulo 2^PHASE_W. When the active bit is 1 the tuning word is carrier+deviation, and when it is 0 the word is carrier-deviation. The phase is never cleared at a bit boundary.
- R3: Let k be the top LUT_AW phase bits and A = 2^(OUT_W-1)-1. sample_out, a two's-complement value, equals round(A*sin((2k+1)*pi/2^LUT_AW)), with rounding symmetric about zero. It is registered one clock after the phase value.
- R4: On every clock the bit accumulator adds the active rate word. A carry out of RATE_W bits is a bit boundary, and bit_req is high for the clock that follows it. Over N clocks the number of pulses is within one of N*rate/2^RATE_W.
- R5: A write with cfg_we high loads a shadow word selected by cfg_addr: 0 carrier, 1 deviation, 2 rate (the low RATE_W bits). Address 3 is ignored. The shadow words become active only at the next bit boundary. Until then the tone and the bit period stay unchanged.
- R6: bit_in is captured only in a clock where bit_valid is high, and it is ignored otherwise. At each bit boundary the last captured bit becomes the active bit. If no new bit was captured, the previous bit is sent again.
- R7: While the active and previous rate words are both below 2^(RATE_W-1), every bit_req pulse is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | PHASE_W | Register write data |
| bit_in | input | 1 | Next data bit |
| bit_valid | input | 1 | Strobe that captures bit_in |
| bit_req | output | 1 | One-clock pulse after a bit boundary |
| sample_out | output | OUT_W | Signed sine sample |

## Verification
The bench builds the block with 16-bit phase and rate words, a 6-bit table address and a 12-bit output. The initial rate word is 0x0400 and the initial carrier and deviation words are zero. With these values a bit lasts exactly 64 clocks, and a tuning word of 0x0400 steps through one table entry per clock. This lets the bench compare every entry of the full sine cycle exactly, and follow it across a bit boundary. Tuning words of 0x8000, 0x4000, 0x2000 and 0x1000 give sample sequences whose half-period is a whole number of clocks, so mark and space can be told apart from the sign pattern alone. A rate word of 0x6666 makes the bit period fractional (2.5 clocks), which exposes drift and double-width pulses.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
   typedef enum logic [1:0] {
      SEL_CARRIER   = 2'd0,
      SEL_DEVIATION = 2'd1,
      SEL_RATE      = 2'd2,
      SEL_UNUSED    = 2'd3
   } cfg_sel_e;

   localparam real PI_R = 3.14159265358979;
endpackage

// File: rtl/fsk_cfg_regs.sv
module fsk_cfg_regs
   import fsk_pkg::*;
#(
   parameter int PHASE_W = 32,
   parameter int RATE_W  = 32,
   parameter logic [PHASE_W-1:0] DEF_CAR  = '0,
   parameter logic [PHASE_W-1:0] DEF_DEV  = '0,
   parameter logic [RATE_W-1:0]  DEF_RATE = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [1:0]         addr,
   input  logic [PHASE_W-1:0] wdata,
   output logic [PHASE_W-1:0] car_q,
   output logic [PHASE_W-1:0] dev_q,
   output logic [RATE_W-1:0]  rate_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_q  <= DEF_CAR;
         dev_q  <= DEF_DEV;
         rate_q <= DEF_RATE;
      end else if (we) begin
         case (cfg_sel_e'(addr))
            SEL_CARRIER:   car_q  <= wdata;
            SEL_DEVIATION: dev_q  <= wdata;
            SEL_RATE:      rate_q <= wdata[RATE_W-1:0];
            default:       ;
         endcase
      end
   end
endmodule

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer #(
   parameter int RATE_W = 32,
   parameter logic [RATE_W-1:0] DEF_RATE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RATE_W-1:0] rate_next,
   output logic [RATE_W-1:0] rate_act,
   output logic              bnd,
   output logic              bit_req
);
   logic [RATE_W-1:0] acc;
   logic [RATE_W:0]   sum;

   assign sum = {1'b0, acc} + {1'b0, rate_act};
   assign bnd = sum[RATE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         rate_act <= DEF_RATE;
         bit_req  <= 1'b0;
      end else begin
         acc     <= sum[RATE_W-1:0];
         bit_req <= bnd;
         if (bnd) rate_act <= rate_next;
      end
   end
endmodule

// File: rtl/fsk_phase_gen.sv
module fsk_phase_gen #(
   parameter int PHASE_W = 32,
   parameter int LUT_AW  = 10,
   parameter logic [PHASE_W-1:0] DEF_CAR = '0,
   parameter logic [PHASE_W-1:0] DEF_DEV = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bnd,
   input  logic               bit_in,
   input  logic               bit_valid,
   input  logic [PHASE_W-1:0] car,
   input  logic [PHASE_W-1:0] dev,
   output logic [PHASE_W-1:0] tw,
   output logic [LUT_AW-1:0]  idx
);
   localparam logic [PHASE_W-1:0] TW_RESET = DEF_CAR - DEF_DEV;

   logic               held_bit;
   logic [PHASE_W-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_bit <= 1'b0;
         tw       <= TW_RESET;
         phase    <= '0;
      end else begin
         if (bit_valid) held_bit <= bit_in;
         if (bnd) tw <= held_bit ? (car + dev) : (car - dev);
         phase <= phase + tw;
      end
   end

   assign idx = phase[PHASE_W-1 -: LUT_AW];
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
   import fsk_pkg::*;
#(
   parameter int LUT_AW = 10,
   parameter int OUT_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LUT_AW-1:0]       idx,
   output logic signed [OUT_W-1:0] sample
);
   localparam int  QW    = LUT_AW - 2;
   localparam int  QN    = 1 << QW;
   localparam real AMP_R = real'((1 << (OUT_W - 1)) - 1);

   logic [OUT_W-2:0] qtab [QN];

   for (genvar i = 0; i < QN; i++) begin : g_qtab
      localparam real ANG = PI_R * (2.0 * i + 1.0) / (4.0 * QN);
      localparam int  MAG = $rtoi(AMP_R * $sin(ANG) + 0.5);
      assign qtab[i] = MAG[OUT_W-2:0];
   end

   logic [1:0]              quad;
   logic [QW-1:0]           low;
   logic [QW-1:0]           mirror;
   logic signed [OUT_W-1:0] mag;

   always_comb begin
      quad   = idx[LUT_AW-1 -: 2];
      low    = idx[QW-1:0];
      mirror = quad[0] ? ~low : low;
      mag    = $signed({1'b0, qtab[mirror]});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sample <= '0;
      else        sample <= quad[1] ? -mag : mag;
   end
endmodule

// File: rtl/fsk_nco_mod.sv
module fsk_nco_mod #(
   parameter int PHASE_W = 32,
   parameter int RATE_W  = 32,
   parameter int LUT_AW  = 10,
   parameter int OUT_W   = 12,
   parameter logic [PHASE_W-1:0] DEF_CAR  = 32'd930576247,
   parameter logic [PHASE_W-1:0] DEF_DEV  = 32'd5368709,
   parameter logic [RATE_W-1:0]  DEF_RATE = 32'd2820343
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [1:0]              cfg_addr,
   input  logic [PHASE_W-1:0]      cfg_wdata,
   input  logic                    bit_in,
   input  logic                    bit_valid,
   output logic                    bit_req,
   output logic signed [OUT_W-1:0] sample_out
);
   if (LUT_AW < 3 || LUT_AW > PHASE_W) begin : g_bad_lut_aw
      $error("LUT_AW must lie in 3..PHASE_W");
   end
   if (RATE_W < 2 || RATE_W > PHASE_W) begin : g_bad_rate_w
      $error("RATE_W must lie in 2..PHASE_W");
   end
   if (OUT_W < 4 || OUT_W > 24) begin : g_bad_out_w
      $error("OUT_W must lie in 4..24");
   end

   logic [PHASE_W-1:0] car_sh;
   logic [PHASE_W-1:0] dev_sh;
   logic [RATE_W-1:0]  rate_sh;
   logic [RATE_W-1:0]  rate_act;
   logic               bnd;
   logic [PHASE_W-1:0] tw;
   logic [LUT_AW-1:0]  idx;

   fsk_cfg_regs #(
      .PHASE_W (PHASE_W), .RATE_W (RATE_W),
      .DEF_CAR (DEF_CAR), .DEF_DEV (DEF_DEV), .DEF_RATE (DEF_RATE)
   ) u_cfg (
      .clk (clk), .rst_n (rst_n), .we (cfg_we), .addr (cfg_addr),
      .wdata (cfg_wdata), .car_q (car_sh), .dev_q (dev_sh), .rate_q (rate_sh)
   );

   fsk_bit_timer #(.RATE_W (RATE_W), .DEF_RATE (DEF_RATE)) u_timer (
      .clk (clk), .rst_n (rst_n), .rate_next (rate_sh),
      .rate_act (rate_act), .bnd (bnd), .bit_req (bit_req)
   );

   fsk_phase_gen #(
      .PHASE_W (PHASE_W), .LUT_AW (LUT_AW),
      .DEF_CAR (DEF_CAR), .DEF_DEV (DEF_DEV)
   ) u_phase (
      .clk (clk), .rst_n (rst_n), .bnd (bnd), .bit_in (bit_in),
      .bit_valid (bit_valid), .car (car_sh), .dev (dev_sh),
      .tw (tw), .idx (idx)
   );

   fsk_sine_lut #(.LUT_AW (LUT_AW), .OUT_W (OUT_W)) u_lut (
      .clk (clk), .rst_n (rst_n), .idx (idx), .sample (sample_out)
   );
endmodule

// File: rtl/fsk_nco_mod_chk.sv
module fsk_nco_mod_chk #(
   parameter int PHASE_W = 32,
   parameter int RATE_W  = 32,
   parameter int OUT_W   = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    bnd,
   input logic                    bit_req,
   input logic [PHASE_W-1:0]      tw,
   input logic [RATE_W-1:0]       rate_act,
   input logic signed [OUT_W-1:0] sample_out
);
   localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

   assert_words_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> ($stable(tw) && $stable(rate_act)));

   assert_req_after_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> bit_req);

   assert_no_stray_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> !bit_req);

   assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && !rate_act[RATE_W-1] && !$past(rate_act[RATE_W-1])) |=> !bit_req);

   always_ff @(posedge clk) begin
      if (rst_n) begin
         assert_sample_range_R3: assert (sample_out != MOST_NEG);
      end else begin
         assert_reset_quiet_R1: assert (sample_out == '0 && !bit_req);
      end
   end
endmodule

bind fsk_nco_mod fsk_nco_mod_chk #(
   .PHASE_W (PHASE_W), .RATE_W (RATE_W), .OUT_W (OUT_W)
) u_chk (
   .clk (clk), .rst_n (rst_n), .bnd (bnd), .bit_req (bit_req),
   .tw (tw), .rate_act (rate_act), .sample_out (sample_out)
);

// File: tb/tb_fsk_nco_mod.sv
module tb_fsk_nco_mod;
   localparam int PW = 16;
   localparam int RW = 16;
   localparam int AW = 6;
   localparam int OW = 12;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 cfg_we = 1'b0;
   logic [1:0]           cfg_addr = '0;
   logic [PW-1:0]        cfg_wdata = '0;
   logic                 bit_in = 1'b0;
   logic                 bit_valid = 1'b0;
   logic                 bit_req;
   logic signed [OW-1:0] sample_out;

   int ntest = 0;
   int nfail = 0;

   fsk_nco_mod #(
      .PHASE_W (PW), .RATE_W (RW), .LUT_AW (AW), .OUT_W (OW),
      .DEF_CAR (16'h0000), .DEF_DEV (16'h0000), .DEF_RATE (16'h0400)
   ) dut (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_addr (cfg_addr),
      .cfg_wdata (cfg_wdata), .bit_in (bit_in), .bit_valid (bit_valid),
      .bit_req (bit_req), .sample_out (sample_out)
   );

   always #10 clk = ~clk;

   // stimulus vectors: carrier, deviation, bit, expected half-period in clocks
   localparam int NV = 5;
   localparam int V_CAR [NV] = '{32'h3000, 32'h3000, 32'h1800, 32'h1800, 32'h6000};
   localparam int V_DEV [NV] = '{32'h1000, 32'h1000, 32'h0800, 32'h0800, 32'h2000};
   localparam int V_BIT [NV] = '{1, 0, 1, 0, 1};
   localparam int V_HALF[NV] = '{2, 4, 4, 8, 1};

   function automatic int exp_entry(int k);
      real r;
      r = 2047.0 * $sin(3.14159265358979 * (2.0 * k + 1.0) / 64.0);
      if (r >= 0.0) return $rtoi(r + 0.5);
      return -$rtoi(-r + 0.5);
   endfunction

   task automatic chk(string req, bit ok, int act, int exp);
      ntest++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [PW-1:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic send_bit(logic b);
      bit_in = b; bit_valid = 1'b1;
      @(negedge clk);
      bit_valid = 1'b0;
   endtask

   task automatic wait_req();
      @(negedge clk);
      while (!bit_req) @(negedge clk);
   endtask

   // records 20 samples after a 3-clock settle, checks sign flip after h and repeat after 2h
   task automatic tone_check(string req, int h);
      int s [20];
      int bad;
      repeat (3) @(negedge clk);
      for (int j = 0; j < 20; j++) begin
         s[j] = int'(sample_out);
         @(negedge clk);
      end
      bad = 0;
      for (int j = 0; j + 2 * h < 20; j++) begin
         if (s[j + h] != -s[j]) bad++;
         if (s[j + 2 * h] != s[j]) bad++;
      end
      chk(req, bad == 0, bad, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
   end

   initial begin
      int n;
      int pulses;
      int bad;
      bit prev;
      repeat (4) @(negedge clk);
      // R1: quiet during reset
      chk("R1 sample in reset", sample_out == 0, int'(sample_out), 0);
      chk("R1 bit_req in reset", bit_req == 1'b0, int'(bit_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3/R2: one table entry per clock, continuing across a bit boundary
      wr(2'd0, 16'h0400);
      wait_req();
      for (int k = 0; k < 80; k++) begin
         @(negedge clk);
         chk("R3 table entry", int'(sample_out) == exp_entry(k % 64),
             int'(sample_out), exp_entry(k % 64));
      end

      // R2/R6: mark and space tones from the vector table
      for (int v = 0; v < NV; v++) begin
         wait_req();
         wr(2'd0, V_CAR[v][PW-1:0]);
         wr(2'd1, V_DEV[v][PW-1:0]);
         send_bit(V_BIT[v][0]);
         wait_req();
         tone_check(V_BIT[v] == 1 ? "R2 mark tone" : "R2 space tone", V_HALF[v]);
      end

      // R6: bit_in without strobe ignored; R5: address 3 ignored
      bit_in = 1'b0;
      wr(2'd3, 16'h1000);
      wait_req();
      wait_req();
      tone_check("R6 R5 ignored inputs keep mark", 1);

      // R5: mid-bit write held until next boundary
      wait_req();
      repeat (20) @(negedge clk);
      wr(2'd0, 16'h1000);
      wr(2'd1, 16'h0000);
      tone_check("R5 old tone until boundary", 1);
      wait_req();
      tone_check("R5 new tone after boundary", 8);

      // R4/R7: bit period and pulse width
      wait_req();
      n = 0;
      @(negedge clk);
      chk("R7 pulse width", bit_req == 1'b0, int'(bit_req), 0);
      n = 1;
      while (!bit_req) begin @(negedge clk); n++; end
      chk("R4 integer bit period", n == 64, n, 64);
      wr(2'd2, 16'h6666);
      n = 1;
      while (!bit_req) begin @(negedge clk); n++; end
      chk("R5 rate held for current bit", n == 64, n, 64);
      repeat (4) @(negedge clk);
      pulses = 0; bad = 0; prev = 1'b0;
      for (int c = 0; c < 1000; c++) begin
         if (bit_req) begin
            pulses++;
            if (prev) bad++;
         end
         prev = bit_req;
         @(negedge clk);
      end
      chk("R4 fractional pulse count", pulses >= 399 && pulses <= 400, pulses, 400);
      chk("R7 no double-width pulse", bad == 0, bad, 0);

      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
   end
endmodule